// File: doc/BRIEF.md
# Serial-Bus Nonvolatile Memory Slave

This block is the slave end of a four-wire serial peripheral bus in front of a byte-wide memory array. A host frames each command by pulling the active-low select line down, clocks in a one-byte opcode and any address and data bytes, and ends the command by raising select. All bus pins are oversampled by the block's system clock. The bus runs in mode 0: input bits are taken on the rising serial clock, and output bits change on the falling serial clock, most significant bit first. The serial clock must stay at each level for at least four system clocks.

The block handles the following commands: write-latch set and clear, status read and write, plain read, read with a dummy byte, streaming write, and an identification readout. Writes go into the array one byte at a time at full bus rate. There is no page buffer and no busy period. Protection works in three layers. A write-enable latch must be set before any write. A low level on the protect pin blocks status writes. Two status bits lock the upper quarter, the upper half or the whole array. The array depth is a power-of-two parameter, and sequential access wraps from the top address back to zero.

Top module: `spi_nvm_slave`

## Requirements
- R1: Input bits are sampled on rising serial-clock edges and output bits change on falling edges, most significant bit first. `spi_miso_oe` is low while select is high, and it is also low during opcode, address and dummy bytes.
- R2: Opcode 06h sets the write latch and opcode 04h clears it. A WRITE (02h) or status write (01h) issued while the latch is clear has no effect.
- R3: The write latch clears when select rises after a 02h or 01h opcode byte has been fully received, whether or not any data followed.
- R4: A status write is ignored while `wp_n` is low.
- R5: Opcode 05h returns the status byte {4'b0, lock[1:0], latch, 1'b0} in every byte clocked out. Bits 3:2 of the status-write data byte load the lock field.
- R6: Opcode 03h takes two address bytes, high byte first, and then streams array bytes from consecutive addresses. Only the low log2(MEM_DEPTH) address bits select the location.
- R7: Opcode 0Bh behaves like 03h, except that one dummy byte separates the address from the first data byte.
- R8: After opcode 02h and the two address bytes, every complete data byte is stored on its eighth rising edge, and the address then advances.
- R9: Sequential reads and writes wrap from address MEM_DEPTH-1 to address 0.
- R10: A lock field of 1 blocks writes to the top quarter of the array, 2 blocks the top half, and 3 blocks all of it. Reads are never blocked.
- R11: Opcode 9Fh returns 7Fh six times, then C2h, then PROD_HI, then PROD_LO, and 00h after that.
- R12: Any other opcode is ignored. The output stays disabled and later bytes in the same frame are not decoded until select rises.
- R13: Raising select ends the command at once. A partial byte is discarded, and this includes a byte whose eighth rising edge arrives in the same cycle as select rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low status-write protect |
| spi_miso | output | 1 | Serial data to the host (0 when disabled) |
| spi_miso_oe | output | 1 | Output enable for spi_miso |

## Verification
Because the pins are oversampled, the eighth rising serial-clock edge of a data byte and the rise of select can land in the same system-clock cycle. In that case the abort must win, yet the write latch must still clear. The bench provokes this by driving the last clock rise and the select release on the same edge in the middle of a WRITE. It judges the outcome by reading the target location back unchanged and by reading a status byte with the latch bit clear.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

  typedef enum logic [3:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_DUMMY, ST_RD, ST_WR, ST_SRW, ST_SRR, ST_ID, ST_SKIP
  } cmd_st_t;

  typedef enum logic [1:0] {K_READ, K_FAST, K_WRITE} xfer_kind_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FSTRD = 8'h0B;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDID  = 8'h9F;

  localparam logic [7:0] ID_CONT   = 8'h7F;
  localparam logic [7:0] ID_MFR    = 8'hC2;
  localparam int         ID_CONT_N = 6;

  // Status byte layout: lock field in bits 3:2, latch in bit 1.
  function automatic logic [7:0] status_byte(input logic latch, input logic [1:0] lock);
    return {4'b0000, lock, latch, 1'b0};
  endfunction

  // Identification stream by byte position.
  function automatic logic [7:0] id_byte(input logic [3:0] idx,
                                         input logic [7:0] hi, input logic [7:0] lo);
    if (int'(idx) < ID_CONT_N)       return ID_CONT;
    else if (int'(idx) == ID_CONT_N) return ID_MFR;
    else if (int'(idx) == ID_CONT_N + 1) return hi;
    else if (int'(idx) == ID_CONT_N + 2) return lo;
    else return 8'h00;
  endfunction

  // True when the lock field forbids writing address a of an aw-bit array.
  function automatic logic in_locked(input logic [14:0] a, input logic [1:0] lock,
                                     input int aw);
    logic [14:0] top;
    top = a >> (aw - 2);
    case (lock)
      2'd0:    return 1'b0;
      2'd1:    return top[1:0] == 2'b11;
      2'd2:    return top[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_nvm_shifter.sv
module spi_nvm_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  input  logic       tx_en,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       cs_rise,
  output logic       miso,
  output logic       miso_oe
);
  logic       sck_q, cs_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       sck_rise, sck_fall;

  assign sck_rise  = sck & ~sck_q;
  assign sck_fall  = ~sck & sck_q;
  assign byte_done = sck_rise & ~cs_n & (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi};
  assign cs_rise   = cs_n & ~cs_q;
  assign miso      = miso_oe & tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      miso_oe <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bit_cnt <= '0;
        miso_oe <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[5:0], mosi};
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (sck_fall) begin
          if (bit_cnt == 3'd0) begin
            tx_sh   <= tx_byte;
            miso_oe <= tx_en;
          end else begin
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_nvm_array.sv
module spi_nvm_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/spi_nvm_cmd.sv
module spi_nvm_cmd
  import spi_nvm_pkg::*;
#(
  parameter int         AW      = 10,
  parameter logic [7:0] PROD_HI = 8'h22,
  parameter logic [7:0] PROD_LO = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cs_rise,
  input  logic          byte_done,
  input  logic [7:0]    rx_byte,
  input  logic          wp_n,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [7:0]    tx_byte,
  output logic          tx_en,
  output logic          wel,
  output logic [1:0]    bp
);
  cmd_st_t    state;
  xfer_kind_t kind;
  logic [AW-1:0] addr, alo_addr;
  logic [3:0]    id_idx;
  logic          clr_pend, rd_pend;

  assign alo_addr = addr | AW'(rx_byte);
  assign tx_en    = (state == ST_SRR) || (state == ST_ID) || (state == ST_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OPC;
      kind      <= K_READ;
      addr      <= '0;
      id_idx    <= '0;
      clr_pend  <= 1'b0;
      rd_pend   <= 1'b0;
      wel       <= 1'b0;
      bp        <= 2'd0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tx_byte   <= '0;
    end else begin
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
      rd_pend <= mem_re;
      if (rd_pend) tx_byte <= mem_rdata;
      if (cs_n) begin
        state <= ST_OPC;
        if (cs_rise && clr_pend) begin
          wel      <= 1'b0;
          clr_pend <= 1'b0;
        end
      end else if (byte_done) begin
        unique case (state)
          ST_OPC: begin
            unique case (rx_byte)
              OP_WREN:  begin wel <= 1'b1; state <= ST_SKIP; end
              OP_WRDI:  begin wel <= 1'b0; state <= ST_SKIP; end
              OP_RDSR:  begin tx_byte <= status_byte(wel, bp); state <= ST_SRR; end
              OP_WRSR:  begin clr_pend <= 1'b1; state <= ST_SRW; end
              OP_READ:  begin kind <= K_READ; state <= ST_AHI; end
              OP_FSTRD: begin kind <= K_FAST; state <= ST_AHI; end
              OP_WRITE: begin kind <= K_WRITE; clr_pend <= 1'b1; state <= ST_AHI; end
              OP_RDID:  begin
                tx_byte <= id_byte(4'd0, PROD_HI, PROD_LO);
                id_idx  <= 4'd1;
                state   <= ST_ID;
              end
              default:  state <= ST_SKIP;
            endcase
          end
          ST_AHI: begin
            addr  <= AW'({rx_byte, 8'h00});
            state <= ST_ALO;
          end
          ST_ALO: begin
            if (kind == K_WRITE) begin
              addr  <= alo_addr;
              state <= ST_WR;
            end else if (kind == K_FAST) begin
              addr  <= alo_addr;
              state <= ST_DUMMY;
            end else begin
              mem_re   <= 1'b1;
              mem_addr <= alo_addr;
              addr     <= alo_addr + 1'b1;
              state    <= ST_RD;
            end
          end
          ST_DUMMY, ST_RD: begin
            mem_re   <= 1'b1;
            mem_addr <= addr;
            addr     <= addr + 1'b1;
            state    <= ST_RD;
          end
          ST_WR: begin
            if (wel && !in_locked(15'(addr), bp, AW)) begin
              mem_we    <= 1'b1;
              mem_addr  <= addr;
              mem_wdata <= rx_byte;
            end
            addr <= addr + 1'b1;
          end
          ST_SRW: begin
            if (wel && wp_n) bp <= rx_byte[3:2];
            state <= ST_SKIP;
          end
          ST_SRR: tx_byte <= status_byte(wel, bp);
          ST_ID: begin
            tx_byte <= id_byte(id_idx, PROD_HI, PROD_LO);
            if (id_idx != 4'hF) id_idx <= id_idx + 4'd1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave #(
  parameter int         MEM_DEPTH = 1024,
  parameter logic [7:0] PROD_HI   = 8'h22,
  parameter logic [7:0] PROD_LO   = 8'h08
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int ADDR_W = $clog2(MEM_DEPTH);

  // Internal events brought out by name for the checker.
  logic              byte_done, cs_rise, tx_en, wel;
  logic [7:0]        rx_byte, tx_byte, mem_wdata, mem_rdata;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0]        bp;

  spi_nvm_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_byte(tx_byte), .tx_en(tx_en), .byte_done(byte_done), .rx_byte(rx_byte),
    .cs_rise(cs_rise), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_nvm_cmd #(.AW(ADDR_W), .PROD_HI(PROD_HI), .PROD_LO(PROD_LO)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .cs_rise(cs_rise),
    .byte_done(byte_done), .rx_byte(rx_byte), .wp_n(wp_n), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .tx_byte(tx_byte), .tx_en(tx_en), .wel(wel), .bp(bp)
  );

  spi_nvm_array #(.DEPTH(MEM_DEPTH), .AW(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/spi_nvm_slave_chk.sv
module spi_nvm_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso_oe,
  input logic       wp_n,
  input logic       byte_done,
  input logic       mem_we,
  input logic       wel,
  input logic [1:0] bp
);
  // R2: an array write only follows a set latch
  assert_we_needs_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wel));

  // R8: an array write is the result of a completed byte
  assert_commit_on_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(byte_done));

  // R4: the lock field changes only with protect pin high and latch set
  assert_status_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> ($past(wp_n) && $past(wel)));

  // R1: output disabled while deselected
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !spi_miso_oe);

  // R13: no byte completes while select is high
  assert_abort_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !byte_done);
endmodule

bind spi_nvm_slave spi_nvm_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .wp_n(wp_n), .byte_done(byte_done), .mem_we(mem_we), .wel(wel), .bp(bp)
);

// File: tb/spi_nvm_slave_tb_top.sv
`timescale 1ns/1ps
module spi_nvm_slave_tb_top;
  localparam int H = 4;
  localparam int NVEC = 8;
  // {addr16, wdata, lock, expected readback}; blocked writes leave ~wdata
  localparam logic [33:0] VEC [NVEC] = '{
    {16'h0010, 8'h5A, 2'd0, 8'h5A},
    {16'h02FF, 8'h3C, 2'd1, 8'h3C},
    {16'h0300, 8'h3C, 2'd1, 8'hC3},
    {16'h01FF, 8'h11, 2'd2, 8'h11},
    {16'h0200, 8'h22, 2'd2, 8'hDD},
    {16'h0000, 8'h77, 2'd3, 8'h88},
    {16'h83FF, 8'h99, 2'd0, 8'h99},
    {16'h7C01, 8'hC3, 2'd1, 8'hC3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  spi_nvm_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .wp_n(wp_n), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    cs_on(); xbyte(op, r); cs_off();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] r;
    cs_on(); xbyte(8'h05, r); xbyte(8'h00, v); cs_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    op1(8'h06);
    cs_on(); xbyte(8'h01, r); xbyte(v, r); cs_off();
  endtask

  task automatic write_raw(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_on(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r); xbyte(d, r); cs_off();
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] d);
    op1(8'h06); write_raw(a, d);
  endtask

  task automatic read1(input logic fast, input logic [15:0] a, output logic [7:0] v);
    logic [7:0] r;
    cs_on();
    xbyte(fast ? 8'h0B : 8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    if (fast) xbyte(8'h00, r);
    xbyte(8'h00, v);
    cs_off();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, r;
    logic [7:0] id_exp [10];
    id_exp = '{8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'hC2, 8'h22, 8'h08, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Reset state
    check8("R1 reset oe", {7'b0, miso_oe}, 8'h00);
    rdsr(v); check8("R5 reset status", v, 8'h00);

    // Vector table: lock tiers, address truncation, readback
    for (int k = 0; k < NVEC; k++) begin
      wrsr(8'h00);
      write1(VEC[k][33:18], ~VEC[k][17:10]);
      wrsr({4'b0, VEC[k][9:8], 2'b00});
      write1(VEC[k][33:18], VEC[k][17:10]);
      read1(1'b0, VEC[k][33:18], v);
      check8($sformatf("R10 R6 vec%0d", k), v, VEC[k][7:0]);
      wrsr(8'h00);
    end
    read1(1'b0, 16'h03FF, v); check8("R6 alias", v, 8'h99);

    // R2 latch set/clear and write without latch
    op1(8'h06); rdsr(v); check8("R2 set latch", v, 8'h02);
    op1(8'h04); rdsr(v); check8("R2 clear latch", v, 8'h00);
    write_raw(16'h0010, 8'h00);
    read1(1'b0, 16'h0010, v); check8("R2 write w/o latch", v, 8'h5A);

    // R3 latch cleared by bare write opcode
    op1(8'h06);
    cs_on(); xbyte(8'h02, r); cs_off();
    rdsr(v); check8("R3 bare write opcode", v, 8'h00);

    // R4 status write under protect pin
    wp_n = 1'b0; wrsr(8'h0C); wp_n = 1'b1;
    rdsr(v); check8("R4 protected wrsr", v, 8'h00);
    wrsr(8'h0C);
    rdsr(v); check8("R5 R3 wrsr lock", v, 8'h0C);
    wrsr(8'h00);

    // R1 output enable timing around a status read
    op1(8'h06);
    cs_on(); xbyte(8'h05, r);
    repeat (H) @(negedge clk);
    check8("R1 oe in data", {7'b0, miso_oe}, 8'h01);
    xbyte(8'h00, v); check8("R5 repeated status", v, 8'h02);
    cs_off();
    check8("R1 oe after cs", {7'b0, miso_oe}, 8'h00);
    op1(8'h04);

    // R7 fast read, two bytes
    cs_on(); xbyte(8'h0B, r); xbyte(8'h01, r); xbyte(8'hFF, r);
    check8("R7 oe low pre-dummy", {7'b0, miso_oe}, 8'h00);
    xbyte(8'h00, r); xbyte(8'h00, v); check8("R7 fast first", v, 8'h11);
    xbyte(8'h00, v); check8("R7 fast second", v, 8'hDD);
    cs_off();
    read1(1'b1, 16'h0010, v); check8("R7 fast single", v, 8'h5A);

    // R8 R9 streaming write across the top
    op1(8'h06);
    cs_on(); xbyte(8'h02, r); xbyte(8'h03, r); xbyte(8'hFE, r);
    xbyte(8'hA1, r); xbyte(8'hA2, r); xbyte(8'hA3, r); cs_off();
    cs_on(); xbyte(8'h03, r); xbyte(8'h03, r); xbyte(8'hFE, r);
    xbyte(8'h00, v); check8("R8 seq 0", v, 8'hA1);
    xbyte(8'h00, v); check8("R8 seq 1", v, 8'hA2);
    xbyte(8'h00, v); check8("R9 wrap read", v, 8'hA3);
    cs_off();
    read1(1'b0, 16'h0000, v); check8("R9 wrap write", v, 8'hA3);

    // R11 identification stream
    cs_on(); xbyte(8'h9F, r);
    for (int k = 0; k < 10; k++) begin
      xbyte(8'h00, v); check8($sformatf("R11 id%0d", k), v, id_exp[k]);
    end
    cs_off();

    // R12 unknown opcode swallows the frame
    cs_on(); xbyte(8'hAA, r);
    repeat (H) @(negedge clk);
    check8("R12 oe after unknown", {7'b0, miso_oe}, 8'h00);
    xbyte(8'h06, r); cs_off();
    rdsr(v); check8("R12 later byte ignored", v, 8'h00);

    // R13 partial byte then abort
    write1(16'h0040, 8'h5E);
    op1(8'h06);
    cs_on(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h40, r);
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b0; repeat (H) @(negedge clk); sck = 1'b1;
      repeat (H) @(negedge clk); sck = 1'b0;
    end
    cs_off();
    read1(1'b0, 16'h0040, v); check8("R13 partial discarded", v, 8'h5E);

    // R13 collision: eighth rise and select release in one cycle
    op1(8'h06);
    cs_on(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h40, r);
    for (int i = 0; i < 7; i++) begin
      mosi = 1'b1; repeat (H) @(negedge clk); sck = 1'b1;
      repeat (H) @(negedge clk); sck = 1'b0;
    end
    mosi = 1'b1; repeat (H) @(negedge clk);
    sck = 1'b1; cs_n = 1'b1;
    repeat (H) @(negedge clk); sck = 1'b0;
    repeat (4) @(negedge clk);
    read1(1'b0, 16'h0040, v); check8("R13 collision discarded", v, 8'h5E);
    rdsr(v); check8("R3 latch cleared on collision", v, 8'h00);

    summary();
    $finish;
  end
endmodule